// File: doc/BRIEF.md
# Serial Transceiver with Line Break Control

This block is a byte-wide serial transmitter and receiver. It works in two modes. In asynchronous mode it uses start and stop bits with optional parity and 16x oversampling. In clock-synchronous mode it shifts eight bits against an externally supplied serial clock. A small register bus gives access to four registers: transmit/receive data, status, control, and a pin-override register.

The pin-override register can take the transmit pin away from the shifter at any moment. It can then hold the line at mark, force a break, or release the pin to high impedance. The receiver reports parity, framing and overrun errors. It also exposes the live receive-pin level, so software can confirm a break. In synchronous mode these error flags lock out transmission until software clears them. Disabling the receiver does not clear them.

Register map (two-bit address):

- 0 is DATA. A write loads the transmit buffer. A read with the read strobe returns the received byte.
- 1 is STATUS:
  - bit0: transmit buffer empty
  - bit1: transmitter idle
  - bit2: receive byte ready
  - bit3: overrun
  - bit4: parity error
  - bit5: framing error
  - bit6: live receive-pin level
- 2 is CTRL:
  - bit0: transmit enable
  - bit1: receive enable
  - bit2: synchronous mode
  - bit3: parity enable
  - bit4: odd parity
- 3 is PINCTL:
  - bit0: override select
  - bit1: override direction, where 1 means output
  - bit2: override level

Top module: `sxb_top`

## Requirements
- R1: In asynchronous mode a written byte is sent as follows. First a low start bit. Then the eight data bits, least significant first. Then a parity bit, when CTRL bit3 is set. Last a high stop bit. Each bit lasts 16 ticks, and each tick lasts TICK_DIV clocks. The idle line is high.
- R2: The receiver takes each bit as the majority of three samples at mid-bit. It places the byte at address 0 and sets STATUS bit2. A read of address 0 with the read strobe clears STATUS bit2.
- R3: The parity bit makes the total count of ones even, or odd when CTRL bit4 is set. A received frame whose parity mismatches sets STATUS bit4.
- R4: A frame whose stop bit samples low sets STATUS bit5. A break therefore sets it. Because the receiver keeps running, a break still present after software clears the flag sets it again on the next frame.
- R5: STATUS bit6 reads the synchronized level of the receive pin.
- R6: With PINCTL bit0 and bit1 set and bit2 clear, the transmit pin is driven low with output enable high. This holds even in the middle of a frame.
- R7: With PINCTL bits 0, 1 and 2 all set, the transmit pin stays high, whatever the transmitter is doing.
- R8: With PINCTL bit0 set and bit1 clear, the pin output enable is low.
- R9: In synchronous mode no transmission starts while STATUS bit3, bit4 or bit5 is set, even though a byte is waiting (STATUS bit0 stays 0). Once the flags are cleared, the transmission starts.
- R10: The error flags are cleared only by writing 0 to their STATUS bits. Writing 1 has no effect. Clearing CTRL bit1 leaves them unchanged.
- R11: A frame that completes while STATUS bit2 is set sets STATUS bit3 and leaves the unread byte in place.
- R12: In synchronous mode the transmit pin presents bit0 when the byte is loaded. It advances one bit on each falling edge of the serial clock. The receiver captures a bit on each rising edge, least significant first, and completes a byte after eight rising edges.
- R13: After reset the transmit pin is high with output enable high, and STATUS reads 0x43 while the receive pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; consumes the received byte at address 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rxd_pin | input | 1 | Serial receive pin |
| sclk_in | input | 1 | Serial clock for synchronous mode |
| txd_out | output | 1 | Serial transmit pin level |
| txd_oe | output | 1 | Transmit pin output enable |

## Verification
Suppose the receive bit counter or oversample phase is wrong. Then the byte read back over a loopback would be wrong, or the parity and framing flags would be set, within a single frame of about 350 clocks. A stale flag, or a flag cleared wrongly by disabling the receiver, shows at the next STATUS read. In synchronous mode it also leaves the transmit buffer stuck non-empty within a few clocks of the flag clear. Override faults show on the pin in the very next cycle, because the mux is combinational behind the register.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_PIN  = 2'd3;

  typedef struct packed {
    logic par_odd;
    logic par_en;
    logic sync_mode;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef struct packed {
    logic lvl;
    logic dir;
    logic sel;
  } pinctl_t;

  // two-of-three vote on the mid-bit samples
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // parity bit that makes the ones count even (odd when odd_sel is set)
  function automatic logic par_of(input logic [7:0] d, input logic odd_sel);
    return (^d) ^ odd_sel;
  endfunction
endpackage

// File: rtl/sxb_rx.sv
module sxb_rx import sxb_pkg::*; #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       sync_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       tick,
  input  logic       sclk_rise,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       par_bad,
  output logic       stop_bad
);
  localparam int OSW = $clog2(OS);
  localparam logic [OSW-1:0] MID = OSW'(OS / 2);

  logic           busy;
  logic [OSW-1:0] os_cnt;
  logic [3:0]     bitn;
  logic [1:0]     samp;
  logic [7:0]     shreg;
  logic           pbit;
  logic           vote;
  logic [3:0]     last_bit;

  assign vote     = maj3(samp[0], samp[1], rxd);
  assign last_bit = par_en ? 4'd10 : 4'd9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; os_cnt <= '0; bitn <= '0; samp <= '0; shreg <= '0;
      pbit <= 1'b0; done <= 1'b0; data <= '0; par_bad <= 1'b0; stop_bad <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
        bitn <= '0;
      end else if (sync_mode) begin
        if (sclk_rise) begin
          shreg <= {rxd, shreg[7:1]};
          if (bitn == 4'd7) begin
            bitn     <= '0;
            done     <= 1'b1;
            data     <= {rxd, shreg[7:1]};
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
          end else begin
            bitn <= bitn + 4'd1;
          end
        end
      end else if (tick) begin
        if (!busy) begin
          if (!rxd) begin
            busy   <= 1'b1;
            os_cnt <= OSW'(1);
            bitn   <= '0;
          end
        end else begin
          os_cnt <= os_cnt + OSW'(1);
          if (os_cnt == MID - OSW'(1)) samp[0] <= rxd;
          if (os_cnt == MID)           samp[1] <= rxd;
          if (os_cnt == MID + OSW'(1)) begin
            bitn <= bitn + 4'd1;
            if (bitn == 4'd0) begin
              if (vote) busy <= 1'b0;          // false start
            end else if (bitn <= 4'd8) begin
              shreg <= {vote, shreg[7:1]};
            end else if (bitn == last_bit) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              data     <= shreg;
              stop_bad <= !vote;
              par_bad  <= par_en && (par_of(shreg, par_odd) != pbit);
            end else begin
              pbit <= vote;
            end
          end
        end
      end
    end
  end

  // R2: a disabled receiver reports no completed frame
  p_rx_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);
endmodule

// File: rtl/sxb_tx.sv
module sxb_tx import sxb_pkg::*; #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_mode,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       tick,
  input  logic       sclk_fall,
  input  logic       start,
  input  logic [7:0] din,
  output logic       busy,
  output logic       txd
);
  localparam int OSW = $clog2(OS);
  localparam logic [OSW-1:0] LAST_TICK = OSW'(OS - 1);

  logic [10:0]    sh;
  logic [3:0]     cnt;
  logic [OSW-1:0] os_cnt;
  logic           step;

  assign step = sync_mode ? sclk_fall : (tick && os_cnt == LAST_TICK);
  assign txd  = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sh <= '1; cnt <= '0; os_cnt <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      os_cnt <= '0;
      if (sync_mode) begin
        sh  <= {3'b111, din};
        cnt <= 4'd8;
      end else begin
        sh  <= {1'b1, par_en ? par_of(din, par_odd) : 1'b1, din, 1'b0};
        cnt <= par_en ? 4'd11 : 4'd10;
      end
    end else if (busy) begin
      if (tick && !sync_mode) os_cnt <= os_cnt + OSW'(1);
      if (step) begin
        sh  <= {1'b1, sh[10:1]};
        cnt <= cnt - 4'd1;
        if (cnt == 4'd1) busy <= 1'b0;
      end
    end
  end

  // R1: an asynchronous frame opens with a low start bit
  p_start_bit_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !sync_mode |-> !txd);
endmodule

// File: rtl/sxb_pinmux.sv
module sxb_pinmux (
  input  logic tx_line,
  input  logic ovr_sel,
  input  logic ovr_dir,
  input  logic ovr_lvl,
  output logic pin,
  output logic oe
);
  always_comb begin
    if (ovr_sel) begin
      pin = ovr_dir ? ovr_lvl : 1'b1;
      oe  = ovr_dir;
    end else begin
      pin = tx_line;
      oe  = 1'b1;
    end
  end
endmodule

// File: rtl/sxb_top.sv
module sxb_top import sxb_pkg::*; #(
  parameter int TICK_DIV = 2,
  parameter int OS       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rxd_pin,
  input  logic       sclk_in,
  output logic       txd_out,
  output logic       txd_oe
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  ctrl_t   ctrl;
  pinctl_t pctl;
  logic [7:0] tdr, rdr;
  logic tx_empty, rx_full, ovr_err, par_err, frm_err;
  logic [TW-1:0] tick_cnt;
  logic tick;
  logic [1:0] rxd_sync;
  logic [2:0] sclk_sync;
  logic sclk_rise, sclk_fall, rxd_s;
  logic tx_busy, tx_line, tx_start, err_any;
  logic rx_done, rx_par_bad, rx_stop_bad;
  logic [7:0] rx_data;
  logic wr_data, wr_stat, wr_ctrl, wr_pin, rd_data;

  assign wr_data = bus_wr && bus_addr == A_DATA;
  assign wr_stat = bus_wr && bus_addr == A_STAT;
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign wr_pin  = bus_wr && bus_addr == A_PIN;
  assign rd_data = bus_rd && bus_addr == A_DATA;

  // oversample tick and input synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0; tick <= 1'b0; rxd_sync <= 2'b11; sclk_sync <= '0;
    end else begin
      tick      <= (tick_cnt == TW'(TICK_DIV - 1));
      tick_cnt  <= (tick_cnt == TW'(TICK_DIV - 1)) ? '0 : tick_cnt + TW'(1);
      rxd_sync  <= {rxd_sync[0], rxd_pin};
      sclk_sync <= {sclk_sync[1:0], sclk_in};
    end
  end
  assign rxd_s     = rxd_sync[1];
  assign sclk_rise = sclk_sync[1] && !sclk_sync[2];
  assign sclk_fall = !sclk_sync[1] && sclk_sync[2];

  assign err_any  = ovr_err | par_err | frm_err;
  assign tx_start = ctrl.tx_en && !tx_empty && !tx_busy && !(ctrl.sync_mode && err_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; pctl <= '0; tdr <= '0; rdr <= '0; tx_empty <= 1'b1;
      rx_full <= 1'b0; ovr_err <= 1'b0; par_err <= 1'b0; frm_err <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata[4:0]);
      if (wr_pin)  pctl <= pinctl_t'(bus_wdata[2:0]);
      if (tx_start) tx_empty <= 1'b1;
      if (wr_data) begin
        tdr      <= bus_wdata;
        tx_empty <= 1'b0;
      end
      if (rd_data) rx_full <= 1'b0;
      if (wr_stat) begin
        ovr_err <= ovr_err & bus_wdata[3];
        par_err <= par_err & bus_wdata[4];
        frm_err <= frm_err & bus_wdata[5];
      end
      if (rx_done) begin
        if (rx_full) begin
          ovr_err <= 1'b1;
        end else begin
          rdr     <= rx_data;
          rx_full <= 1'b1;
        end
        if (rx_par_bad)  par_err <= 1'b1;
        if (rx_stop_bad) frm_err <= 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = rdr;
      A_STAT:  bus_rdata = {1'b0, rxd_s, frm_err, par_err, ovr_err, rx_full,
                            tx_empty && !tx_busy, tx_empty};
      A_CTRL:  bus_rdata = {3'b000, ctrl};
      default: bus_rdata = {5'b00000, pctl};
    endcase
  end

  sxb_tx #(.OS(OS)) u_tx (
    .clk(clk), .rst_n(rst_n), .sync_mode(ctrl.sync_mode), .par_en(ctrl.par_en),
    .par_odd(ctrl.par_odd), .tick(tick), .sclk_fall(sclk_fall), .start(tx_start),
    .din(tdr), .busy(tx_busy), .txd(tx_line)
  );

  sxb_rx #(.OS(OS)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl.rx_en), .sync_mode(ctrl.sync_mode),
    .par_en(ctrl.par_en), .par_odd(ctrl.par_odd), .tick(tick), .sclk_rise(sclk_rise),
    .rxd(rxd_s), .done(rx_done), .data(rx_data), .par_bad(rx_par_bad),
    .stop_bad(rx_stop_bad)
  );

  sxb_pinmux u_pin (
    .tx_line(tx_line), .ovr_sel(pctl.sel), .ovr_dir(pctl.dir), .ovr_lvl(pctl.lvl),
    .pin(txd_out), .oe(txd_oe)
  );

  // R6/R7: an output override owns the pin, whatever the shifter does
  p_override_owns_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pctl.sel && pctl.dir |-> txd_out == pctl.lvl && txd_oe);
  // R8: input direction releases the pin
  p_override_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pctl.sel && !pctl.dir |-> !txd_oe);
  // R9: a pending error keeps the synchronous shifter idle
  p_sync_interlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.sync_mode && err_any && !tx_busy |=> !tx_busy);
  // R4: a low stop sample raises the framing flag
  p_stop_low_frames_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_stop_bad |=> frm_err);
  // R11: a frame landing on an unread byte raises overrun and keeps the byte
  p_overrun_on_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_full |=> ovr_err && $stable(rdr));
  // R10: turning the receiver off leaves the flags alone
  p_flags_survive_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && !bus_wdata[1] && !rx_done |=> $stable({ovr_err, par_err, frm_err}));
endmodule

// File: tb/sxb_top_bench.sv
module sxb_top_bench;
  localparam int BIT_CLKS = 32;   // 16 ticks x TICK_DIV of 2

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic rxd_drv = 1'b1, loop_en = 1'b0, sclk = 1'b0;
  logic rxd_pin, txd_out, txd_oe;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;
  assign rxd_pin = loop_en ? txd_out : rxd_drv;

  sxb_top u_sxb_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd_pin(rxd_pin), .sclk_in(sclk),
    .txd_out(txd_out), .txd_oe(txd_oe)
  );

  // data, parity enable, odd parity
  localparam logic [9:0] VEC [6] = '{
    {8'h55, 1'b0, 1'b0}, {8'hA3, 1'b1, 1'b0}, {8'h3C, 1'b1, 1'b1},
    {8'h00, 1'b1, 1'b1}, {8'hFF, 1'b1, 1'b0}, {8'h81, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_rx_full();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rd(2'd1, s);
      if (s[2]) break;
      wait_clks(8);
    end
  endtask

  function automatic logic bench_par(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return ((ones % 2) == 1) ^ odd;
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit has_par, input logic pb,
                            input logic stopv);
    @(negedge clk); rxd_drv = 1'b0; wait_clks(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin rxd_drv = d[i]; wait_clks(BIT_CLKS); end
    if (has_par) begin rxd_drv = pb; wait_clks(BIT_CLKS); end
    rxd_drv = stopv; wait_clks(BIT_CLKS);
    rxd_drv = 1'b1; wait_clks(2 * BIT_CLKS);
  endtask

  task automatic sclk_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; wait_clks(20);
      sclk = 1'b0; wait_clks(20);
    end
  endtask

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic ok_all;
    wait_clks(4);
    rst_n = 1'b1;
    wait_clks(4);

    // R13 reset state
    rd(2'd1, v);
    chk(v == 8'h43, "R13 status after reset", v, 8'h43);
    chk(txd_out && txd_oe, "R13 pin after reset", {txd_out, txd_oe}, 2'b11);

    // R1 R2 R3 loopback vectors
    loop_en = 1'b1;
    foreach (VEC[k]) begin
      wr(2'd2, {3'b000, VEC[k][0], VEC[k][1], 1'b0, 1'b1, 1'b1});
      wr(2'd0, VEC[k][9:2]);
      wait_rx_full();
      rd(2'd0, v);
      chk(v == VEC[k][9:2], "R1 R2 loopback data", v, VEC[k][9:2]);
      rd(2'd1, v);
      chk(v[5:2] == 4'b0000, "R3 loopback clean flags", v[5:2], 0);
      wait_clks(2 * BIT_CLKS);
    end
    loop_en = 1'b0;

    // R3 parity mismatch, even parity
    wr(2'd2, 8'b0000_1010);
    send_frame(8'h01, 1'b1, ~bench_par(8'h01, 1'b0), 1'b1);
    rd(2'd1, v);
    chk(v[4] && !v[5], "R3 parity error flagged", v, 8'h14);
    rd(2'd0, v);
    chk(v == 8'h01, "R2 data despite parity error", v, 8'h01);
    wr(2'd1, 8'h00);

    // R11 overrun
    wr(2'd2, 8'b0000_0010);
    send_frame(8'h11, 1'b0, 1'b0, 1'b1);
    send_frame(8'h22, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v);
    chk(v[3] && v[2], "R11 overrun flagged", v, 8'h0C);
    rd(2'd0, v);
    chk(v == 8'h11, "R11 first byte kept", v, 8'h11);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    chk(v[5:3] == 3'b000, "R10 write 0 clears flags", v[5:3], 0);

    // R4 R5 break
    @(negedge clk); rxd_drv = 1'b0;
    wait_clks(11 * BIT_CLKS);
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R4 break sets framing error", v, 8'h20);
    chk(v[6] == 1'b0, "R5 live pin low during break", v[6], 0);
    rd(2'd0, v);
    chk(v == 8'h00, "R4 break byte", v, 8'h00);
    wr(2'd1, 8'h00);
    rd(2'd1, v);
    chk(v[5] == 1'b0, "R4 flag cleared by software", v[5], 0);
    wait_clks(12 * BIT_CLKS);
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R4 framing error sets again", v[5], 1);
    rxd_drv = 1'b1;
    wait_clks(25 * BIT_CLKS);
    rd(2'd1, v);
    chk(v[6] == 1'b1, "R5 live pin high", v[6], 1);

    // R10 flags survive receiver disable and write of 1
    wr(2'd2, 8'b0000_0000);
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R10 flag kept after rx disable", v[5], 1);
    wr(2'd1, 8'hFF);
    rd(2'd1, v);
    chk(v[5] == 1'b1, "R10 write 1 no effect", v[5], 1);

    // R9 synchronous interlock
    wr(2'd2, 8'b0000_0101);
    wr(2'd0, 8'hA5);
    wait_clks(20);
    rd(2'd1, v);
    chk(v[0] == 1'b0, "R9 transmit held by error flags", v[0], 0);
    chk(txd_out == 1'b1, "R9 line idle while held", txd_out, 1);
    wr(2'd1, 8'h00);
    wait_clks(5);
    rd(2'd1, v);
    chk(v[0] == 1'b1 && v[5:3] == 3'b000, "R9 transmit starts after clear", v, 8'h01);
    sclk_pulses(8);
    wait_clks(10);

    // R12 synchronous loopback
    wr(2'd1, 8'h00);
    wr(2'd2, 8'b0000_0111);
    rd(2'd0, v);
    loop_en = 1'b1;
    wr(2'd0, 8'h96);
    wait_clks(6);
    chk(txd_out == 1'b0, "R12 bit0 presented at load", txd_out, 0);
    sclk_pulses(8);
    wait_clks(10);
    rd(2'd1, v);
    chk(v[2] == 1'b1, "R12 sync byte received", v, 8'h04);
    rd(2'd0, v);
    chk(v == 8'h96, "R12 sync data", v, 8'h96);
    loop_en = 1'b0;

    // R6 break override mid-frame
    wr(2'd2, 8'b0000_0001);
    wr(2'd0, 8'hFF);
    wait_clks(3 * BIT_CLKS);
    wr(2'd3, 8'b0000_0011);
    wait_clks(2);
    ok_all = 1'b1;
    for (int i = 0; i < 100; i++) begin
      if (txd_out !== 1'b0 || txd_oe !== 1'b1) ok_all = 1'b0;
      @(negedge clk);
    end
    chk(ok_all, "R6 forced break mid-frame", {txd_out, txd_oe}, 2'b01);
    wr(2'd3, 8'h00);
    wait_clks(12 * BIT_CLKS);

    // R7 mark override through a whole frame
    wr(2'd3, 8'b0000_0111);
    wr(2'd0, 8'h00);
    ok_all = 1'b1;
    for (int i = 0; i < 11 * BIT_CLKS; i++) begin
      if (txd_out !== 1'b1 || txd_oe !== 1'b1) ok_all = 1'b0;
      @(negedge clk);
    end
    chk(ok_all, "R7 mark held over frame", {txd_out, txd_oe}, 2'b11);

    // R8 input direction releases the pin
    wr(2'd3, 8'b0000_0001);
    wait_clks(2);
    chk(txd_oe == 1'b0, "R8 output enable released", txd_oe, 0);
    wr(2'd3, 8'h00);
    wait_clks(2);
    chk(txd_oe == 1'b1, "R8 output enable restored", txd_oe, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule